// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single channel of a high-resolution event timer. A shared free-running main counter is supplied from outside, and the channel compares it against its own comparator register. When the two are equal, the channel emits a one-cycle pulse on one bit of an interrupt vector. The channel has two modes. In one-shot mode it fires on each match. In periodic mode it adds a hidden period value to the comparator after each match. A 32-bit mode restricts the comparator, the period and the comparison to their low halves. In 32-bit one-shot mode an extra pulse is raised when the low counter half rolls over before the match.

Software reaches the channel through 32-bit write strobes for the lower configuration word and for the two halves of the comparator word. It reads the configuration and the comparator back as full 64-bit words. The pulse line comes from a five-bit route field. When a legacy-mode input is set, channels 0 and 1 use fixed lines instead. A pulse is emitted only while both the channel enable and the global enable are set.

Configuration bits of the lower word:

| Bit | Meaning |
|-----|---------|
| 2 | enable |
| 3 | periodic |
| 4 | periodic capable (read-only 1) |
| 5 | 64-bit capable (read-only 1) |
| 6 | set-value |
| 8 | 32-bit mode |
| 13:9 | route |

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the configuration reads 0x00000004_00000030, the comparator reads all ones and no interrupt bit is set.
- R2: A configuration write changes only bits 2, 3, 6, 8 and 13:9 of the lower word. The upper word always reads 0x00000004, and bits 4 and 5 always read 1.
- R3: In one-shot mode, a pulse appears on the line selected by route bits 13:9 one cycle after the counter is presented equal to the comparator. The pulse lasts one cycle. Holding the counter at the same value does not repeat the pulse. At most one interrupt bit is set at a time.
- R4: In periodic mode with set-value clear, a write to either comparator half loads the hidden period and leaves the visible comparator unchanged.
- R5: With set-value set, or in one-shot mode, a comparator write loads the visible comparator. Set-value reads 0 after any comparator-half write.
- R6: On a periodic match with a nonzero period, the comparator advances by the period. Pulses then recur every period counts.
- R7: Period writes force the period's top bit to zero: bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R8: No pulse is emitted unless both the channel enable (bit 2) and the global enable are set.
- R9: Writing the configuration with bit 8 set truncates the comparator and the period to their low 32 bits. In 32-bit mode, comparator-high writes are ignored and matching uses only the low 32 counter bits.
- R10: In 32-bit periodic mode, the advanced comparator is the sum modulo 2^32.
- R11: In 32-bit one-shot mode, a low-half rollover from all ones to zero raises a pulse if no pulse has occurred since the last register write or arming. The later match still pulses, and a second rollover does not. Periodic mode never pulses on rollover.
- R12: With legacy mode set, channel 0 drives line 0 and channel 1 drives line 8, regardless of the route field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| mainCount | input | CNT_W | shared main counter value |
| globalEn | input | 1 | global interrupt and counting enable |
| legacyMode | input | 1 | selects the fixed legacy routes |
| wrData | input | CNT_W/2 | write data for all write strobes |
| cfgWr | input | 1 | write the lower configuration word |
| cmpLoWr | input | 1 | write the lower comparator half |
| cmpHiWr | input | 1 | write the upper comparator half |
| cfgRd | output | CNT_W | configuration readback |
| cmpRd | output | CNT_W | comparator readback |
| irqOut | output | NUM_LINES | one-hot interrupt pulse vector |

## Verification
A counter value presented before a clock edge is compared at that edge. The resulting pulse sits in the output register for the whole following cycle, so the bench drives the counter on a falling edge and samples the interrupt a quarter period after the next rising edge. A register write takes effect at the first rising edge of its strobe, so readback and comparator advance are sampled after that edge, before the next stimulus. Sweeps step the counter one value per cycle through each match window. A bench-side arithmetic model of the expected comparator predicts every cycle's interrupt vector.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CFG_EN    = 2;
  localparam int CFG_PER   = 3;
  localparam int CFG_SETV  = 6;
  localparam int CFG_W32   = 8;
  localparam int CFG_RT_LO = 9;
  localparam int CFG_RT_W  = 5;

  localparam logic [31:0] CFG_WR_MASK = 32'h0000_3F4C;
  localparam logic [31:0] CFG_RST_LO  = 32'h0000_0030;
  localparam logic [31:0] CFG_HI_RO   = 32'h0000_0004;

  typedef struct packed {
    logic cfgWr;
    logic cmpLoWr;
    logic cmpHiWr;
    logic loadCmp;
    logic loadPer;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [CNT_W/2-1:0]     wrData,
  output logic [CNT_W/2-1:0]     cfgLo,
  output logic [CNT_W-1:0]       cmpQ,
  output logic [CNT_W-1:0]       perQ
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] WR_MASK = HALF_W'(CFG_WR_MASK);

  logic is32;
  assign is32 = cfgLo[CFG_W32];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLo <= HALF_W'(CFG_RST_LO);
      cmpQ  <= '1;
      perQ  <= '0;
    end else if (strobe.cfgWr) begin
      cfgLo <= (wrData & WR_MASK) | (cfgLo & ~WR_MASK);
      if (wrData[CFG_W32]) begin
        cmpQ <= {{HALF_W{1'b0}}, cmpQ[HALF_W-1:0]};
        perQ <= {{HALF_W{1'b0}}, 1'b0, perQ[HALF_W-2:0]};
      end
    end else if (strobe.cmpLoWr) begin
      if (strobe.loadCmp) cmpQ[HALF_W-1:0] <= wrData;
      if (strobe.loadPer)
        perQ[HALF_W-1:0] <= is32 ? {1'b0, wrData[HALF_W-2:0]} : wrData;
      cfgLo[CFG_SETV] <= 1'b0;
    end else if (strobe.cmpHiWr) begin
      if (!is32) begin
        if (strobe.loadCmp) cmpQ[CNT_W-1:HALF_W] <= wrData;
        if (strobe.loadPer) perQ[CNT_W-1:HALF_W] <= {1'b0, wrData[HALF_W-2:0]};
      end
      cfgLo[CFG_SETV] <= 1'b0;
    end else if (strobe.advance) begin
      if (is32)
        cmpQ <= {{HALF_W{1'b0}}, cmpQ[HALF_W-1:0] + perQ[HALF_W-1:0]};
      else
        cmpQ <= cmpQ + perQ;
    end
  end

  // R5
  setval_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmpLoWr || strobe.cmpHiWr) |=> !cfgLo[CFG_SETV]);

  // R7
  per_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    perQ[CNT_W-1] == 1'b0);

  // R9
  per_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLo[CFG_W32] |-> (perQ[CNT_W-1:HALF_W-1] == '0 && cmpQ[CNT_W-1:HALF_W] == '0));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cfgWr || strobe.cmpLoWr || strobe.cmpHiWr) |=> $stable(cfgLo));
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int NUM_LINES = 32,
  parameter int CHAN_ID   = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_W-1:0]       mainCount,
  input  logic                   globalEn,
  input  logic                   legacyMode,
  input  logic                   cfgWr,
  input  logic                   cmpLoWr,
  input  logic                   cmpHiWr,
  input  logic [CNT_W/2-1:0]     cfgLo,
  input  logic [CNT_W-1:0]       cmpQ,
  input  logic [CNT_W-1:0]       perQ,
  output dpStrobe_t              strobe,
  output logic [NUM_LINES-1:0]   irqOut
);
  localparam int HALF_W = CNT_W / 2;

  logic is32, periodic, chanEn, setVal, armed, armedPrev;
  logic match, matchPrev, anyWr, hit, wrapNow, wrapHit, wrapArm, fire;
  logic [HALF_W-1:0] cntPrevLow;
  logic [CFG_RT_W-1:0] route, lineSel;
  logic [NUM_LINES-1:0] irqNext;

  assign is32     = cfgLo[CFG_W32];
  assign periodic = cfgLo[CFG_PER];
  assign chanEn   = cfgLo[CFG_EN];
  assign setVal   = cfgLo[CFG_SETV];
  assign route    = cfgLo[CFG_RT_LO +: CFG_RT_W];
  assign armed    = chanEn && globalEn;
  assign anyWr    = cfgWr || cmpLoWr || cmpHiWr;

  assign match   = is32 ? (mainCount[HALF_W-1:0] == cmpQ[HALF_W-1:0])
                        : (mainCount == cmpQ);
  assign hit     = armed && match && !matchPrev;
  assign wrapNow = (cntPrevLow == '1) && (mainCount[HALF_W-1:0] == '0);
  assign wrapHit = armed && is32 && !periodic && wrapArm && wrapNow;
  assign fire    = hit || wrapHit;

  always_comb begin
    strobe.cfgWr   = cfgWr;
    strobe.cmpLoWr = cmpLoWr;
    strobe.cmpHiWr = cmpHiWr;
    strobe.loadCmp = !periodic || setVal;
    strobe.loadPer = periodic;
    strobe.advance = hit && periodic && (perQ != '0) && !anyWr;
  end

  always_comb begin
    lineSel = route;
    if (legacyMode && CHAN_ID == 0)      lineSel = '0;
    else if (legacyMode && CHAN_ID == 1) lineSel = CFG_RT_W'(8);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    assign irqNext[g] = fire && (lineSel == CFG_RT_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPrev  <= 1'b0;
      cntPrevLow <= '0;
      armedPrev  <= 1'b0;
      wrapArm    <= 1'b0;
      irqOut     <= '0;
    end else begin
      matchPrev  <= match && !anyWr && !strobe.advance;
      cntPrevLow <= mainCount[HALF_W-1:0];
      armedPrev  <= armed;
      if (anyWr || (armed && !armedPrev)) wrapArm <= 1'b1;
      else if (fire)                      wrapArm <= 1'b0;
      irqOut     <= irqNext;
    end
  end

  // R3
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> $past(armed));

  // R6
  advance_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !is32) |=> cmpQ == $past(cmpQ) + $past(perQ));

  // R11
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit |=> (|irqOut));

  if (CHAN_ID < 2 && NUM_LINES > 8) begin : gLegacyChk
    // R12
    legacy_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fire && legacyMode) |=> irqOut[CHAN_ID * 8]);
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int NUM_LINES = 32,
  parameter int CHAN_ID   = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_W-1:0]       mainCount,
  input  logic                   globalEn,
  input  logic                   legacyMode,
  input  logic [CNT_W/2-1:0]     wrData,
  input  logic                   cfgWr,
  input  logic                   cmpLoWr,
  input  logic                   cmpHiWr,
  output logic [CNT_W-1:0]       cfgRd,
  output logic [CNT_W-1:0]       cmpRd,
  output logic [NUM_LINES-1:0]   irqOut
);
  localparam int HALF_W = CNT_W / 2;

  dpStrobe_t strobe;
  logic [HALF_W-1:0] cfgLo;
  logic [CNT_W-1:0] cmpQ, perQ;

  cmp_timer_ctrl #(.CNT_W(CNT_W), .NUM_LINES(NUM_LINES), .CHAN_ID(CHAN_ID)) i_ctrl (
    .clk(clk), .rstN(rstN), .mainCount(mainCount), .globalEn(globalEn),
    .legacyMode(legacyMode), .cfgWr(cfgWr), .cmpLoWr(cmpLoWr), .cmpHiWr(cmpHiWr),
    .cfgLo(cfgLo), .cmpQ(cmpQ), .perQ(perQ), .strobe(strobe), .irqOut(irqOut)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cfgLo(cfgLo), .cmpQ(cmpQ), .perQ(perQ)
  );

  assign cfgRd = {HALF_W'(CFG_HI_RO), cfgLo};
  assign cmpRd = cmpQ;
endmodule

// File: tb/test_cmp_timer_chan.sv
module test_cmp_timer_chan;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] mainCount = '0;
  logic globalEn = 1'b0, legacyMode = 1'b0;
  logic [31:0] wrData = '0;
  logic cfgWr = 1'b0, cmpLoWr = 1'b0, cmpHiWr = 1'b0;
  logic [63:0] cfgRd, cmpRd;
  logic [31:0] irqOut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer_chan i_cmp_timer_chan (
    .clk(clk), .rstN(rstN), .mainCount(mainCount), .globalEn(globalEn),
    .legacyMode(legacyMode), .wrData(wrData), .cfgWr(cfgWr), .cmpLoWr(cmpLoWr),
    .cmpHiWr(cmpHiWr), .cfgRd(cfgRd), .cmpRd(cmpRd), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // which: 0 config, 1 comparator low, 2 comparator high
  task automatic wr(input int which, input logic [31:0] d);
    @(negedge clk);
    wrData = d;
    cfgWr = (which == 0); cmpLoWr = (which == 1); cmpHiWr = (which == 2);
    @(posedge clk);
    #(CLK_PERIOD/4);
    cfgWr = 1'b0; cmpLoWr = 1'b0; cmpHiWr = 1'b0;
  endtask

  task automatic tick(input logic [63:0] v);
    @(negedge clk);
    mainCount = v;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] expCmp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #(CLK_PERIOD/4);
    chk("R1 cfg", cfgRd, 64'h0000_0004_0000_0030);
    chk("R1 cmp", cmpRd, '1);
    chk("R1 irq", 64'(irqOut), 64'h0);

    wr(0, 32'hFFFF_FFFF);
    chk("R2 mask", cfgRd, 64'h0000_0004_0000_3F7C);
    chk("R9 truncate", cmpRd, 64'h0000_0000_FFFF_FFFF);
    wr(0, 32'h0);
    chk("R2 clear", cfgRd, 64'h0000_0004_0000_0030);

    // one-shot 64-bit, route 5
    globalEn = 1'b1;
    wr(0, 32'h0000_0A04);
    wr(1, 32'h0000_0100);
    wr(2, 32'h0);
    chk("R5 oneshot load", cmpRd, 64'h100);
    for (int v = 'hF8; v <= 'h108; v++) begin
      tick(64'(v));
      chk("R3 sweep", 64'(irqOut), (v == 'h100) ? 64'h20 : 64'h0);
    end
    tick(64'h100);
    chk("R3 revisit", 64'(irqOut), 64'h20);
    tick(64'h100);
    chk("R3 hold", 64'(irqOut), 64'h0);

    // gating
    wr(0, 32'h0000_0A00);
    tick(64'hFF); tick(64'h100);
    chk("R8 chan off", 64'(irqOut), 64'h0);
    wr(0, 32'h0000_0A04);
    globalEn = 1'b0;
    tick(64'hFF); tick(64'h100);
    chk("R8 global off", 64'(irqOut), 64'h0);
    globalEn = 1'b1;
    tick(64'hFF); tick(64'h100);
    chk("R8 both on", 64'(irqOut), 64'h20);

    // periodic 64-bit, route 3
    tick(64'h50);
    wr(0, 32'h0000_060C);
    wr(1, 32'h0000_0020);
    chk("R4 period only", cmpRd, 64'h100);
    wr(0, 32'h0000_064C);
    wr(1, 32'h0000_0200);
    chk("R5 setval load", cmpRd, 64'h200);
    chk("R5 setval clear", 64'(cfgRd[6]), 64'h0);
    wr(1, 32'h0000_0020);
    wr(2, 32'h0);
    chk("R4 cmp kept", cmpRd, 64'h200);
    expCmp = 64'h200;
    for (int v = 'h1F0; v <= 'h260; v++) begin
      logic fireExp;
      tick(64'(v));
      fireExp = (64'(v) == expCmp);
      chk("R6 sweep", 64'(irqOut), fireExp ? 64'h8 : 64'h0);
      if (fireExp) expCmp = expCmp + 64'h20;
    end
    chk("R6 cmp final", cmpRd, 64'h280);

    wr(1, 32'h0000_0010);
    wr(2, 32'hFFFF_FFFF);
    tick(64'h27F);
    chk("R6 before", 64'(irqOut), 64'h0);
    tick(64'h280);
    chk("R6 match", 64'(irqOut), 64'h8);
    chk("R7 top bit", cmpRd, 64'h7FFF_FFFF_0000_0290);

    // 32-bit one-shot, route 7
    wr(0, 32'h0000_0F04);
    chk("R9 cmp trunc", cmpRd, 64'h290);
    chk("R9 cfg", cfgRd, 64'h0000_0004_0000_0F34);
    wr(2, 32'h0000_FFFF);
    chk("R9 hi ignored", cmpRd, 64'h290);
    tick(64'hABCD_0000_0000_028F);
    chk("R9 no match", 64'(irqOut), 64'h0);
    tick(64'hABCD_0000_0000_0290);
    chk("R9 low match", 64'(irqOut), 64'h80);

    // 32-bit periodic with set-value
    wr(0, 32'h0000_0F4C);
    wr(1, 32'hFFFF_FFF0);
    chk("R5 cmp32", cmpRd, 64'hFFFF_FFF0);
    tick(64'h3_FFFF_FFEF);
    chk("R10 before", 64'(irqOut), 64'h0);
    tick(64'h3_FFFF_FFF0);
    chk("R10 match", 64'(irqOut), 64'h80);
    chk("R10 R7 mod sum", cmpRd, 64'h7FFF_FFE0);
    tick(64'h3_FFFF_FFFF);
    tick(64'h4_0000_0000);
    chk("R11 periodic no wrap", 64'(irqOut), 64'h0);

    // 32-bit one-shot rollover
    tick(64'h5_FFFF_FFF0);
    wr(0, 32'h0000_0F04);
    wr(1, 32'h0000_0010);
    tick(64'h5_FFFF_FFFE);
    chk("R11 pre", 64'(irqOut), 64'h0);
    tick(64'h5_FFFF_FFFF);
    chk("R11 top", 64'(irqOut), 64'h0);
    tick(64'h6_0000_0000);
    chk("R11 wrap", 64'(irqOut), 64'h80);
    tick(64'h6_0000_0001);
    chk("R11 after", 64'(irqOut), 64'h0);
    tick(64'h6_0000_000F);
    chk("R11 near", 64'(irqOut), 64'h0);
    tick(64'h6_0000_0010);
    chk("R11 match", 64'(irqOut), 64'h80);
    tick(64'h6_FFFF_FFFF);
    tick(64'h7_0000_0000);
    chk("R11 second wrap", 64'(irqOut), 64'h0);

    // legacy routing
    legacyMode = 1'b1;
    wr(0, 32'h0000_0E04);
    wr(1, 32'h0000_0050);
    wr(2, 32'h0);
    tick(64'h4F);
    chk("R12 before", 64'(irqOut), 64'h0);
    tick(64'h50);
    chk("R12 legacy line", 64'(irqOut), 64'h100);
    legacyMode = 1'b0;
    tick(64'h4F);
    tick(64'h50);
    chk("R12 route line", 64'(irqOut), 64'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule